// File: doc/BRIEF.md
# Four-Bank GPIO Controller with Edge Capture and Split Interrupts

This block controls 128 general-purpose pins arranged as four banks of 32. Software reaches it through a simple word-wide register bus. The write side is a one-cycle strobe. The read side is a combinational mux on the address. Every pin has the following:
- a direction bit;
- an output latch that is changed only through separate set-only and clear-only registers;
- a level view that shows the latch for outputs and the synchronized pad value for inputs.

Input pins can be armed for rising-edge capture, falling-edge capture, or both. A captured edge lands in a sticky status bit, and software clears that bit by writing a one to it. The status bits feed three interrupt lines:
- one line for pin 0;
- one line for pin 1;
- one shared line for all remaining pins.

A wake request asserts while the processor reports itself halted and an input pin inside a fixed per-bank wake mask changes level. Each bank also has two alternate-function words. These are only stored and read back.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The address map decodes exact byte offsets. For a bank index b below 3, seven register groups sit at 12·g + 4·b, where g runs 0..6 in the order level, direction, set, clear, rise-enable, fall-enable, edge-status. Bank 3 uses the same groups at 0x100 + 12·g. The alternate-function low word sits at 0x54 + 8·b and the high word at 0x58 + 8·b. Direction, rise-enable, fall-enable and both alternate words read back the last value written.
- R2: A write to a set register ORs the data into that bank's output latch. A write to a clear register removes the latch bits where the data has ones. Both registers read as zero.
- R3: A level read returns the output latch where the direction bit is 1 and the synchronized input where it is 0. An input change applied before clock edge k is visible after edge k+1.
- R4: `pinOut` for each pin equals the output latch ANDed with the direction bit.
- R5: A status bit sets on a rising edge of the synchronized input only when its rise-enable bit is 1 and its direction bit is 0. It becomes visible after edge k+2 for an input change applied before edge k.
- R6: Falling edges set status under the same conditions, using the fall-enable bit.
- R7: Status bits are sticky. Writing a 1 clears a bit, and writing a 0 leaves it unchanged. When a clear and a newly captured edge hit the same bit in the same cycle, the bit ends up set.
- R8: `irqPin0` equals bank 0 status bit 0. `irqPin1` equals bank 0 status bit 1. `irqOther` is the OR of bank 0 status bits 31..2 and every status bit of banks 1..3.
- R9: `wakeReq` is high while `cpuHalted` is 1 and a synchronized input pin that is set in the wake mask differs from its previous sample. The masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0..3.
- R10: Offsets at or above 0x200, and unmapped offsets below it, read as zero and change no state.
- R11: While reset is asserted, every register reads zero and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 12 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| pinIn | input | 128 | Pad input levels, pin n at bit n |
| pinOut | output | 128 | Driven pin values, pin n at bit n |
| cpuHalted | input | 1 | Processor is halted |
| irqPin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irqPin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irqOther | output | 1 | Shared interrupt for all other pins |
| wakeReq | output | 1 | Wake request from masked input changes |

## Verification
The interesting collision is a software write of ones to an edge-status register in the same clock as a freshly detected edge on that bit. The bench provokes it by changing a pad two cycles before the clearing write, so that the synchronized edge lands exactly on the write cycle. It then expects the bit to remain set. Collisions between set or clear writes and direction changes, and between random pin activity and status clears, are also exercised. A behavioural model compared on every clock judges them.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_BANKS    = 4;
  localparam int PIN_W        = 32;
  localparam int ADDR_W       = 12;
  localparam int BANK_W       = $clog2(NUM_BANKS);
  localparam int TOTAL_PINS   = NUM_BANKS * PIN_W;
  localparam int GROUPS       = 7;
  localparam int GROUP_STRIDE = 12;
  localparam int LOW_BANKS    = 3;
  localparam int HIGH_BASE    = 'h100;
  localparam int ALT_BASE     = 'h54;
  localparam int ALT_STRIDE   = 8;
  localparam int SPACE_END    = 'h200;

  typedef enum logic [3:0] {
    K_NONE, K_LEVEL, K_DIR, K_SET, K_CLR, K_RISE, K_FALL, K_EDGE, K_ALTLO, K_ALTHI
  } regKindE;

  typedef struct packed {
    logic              wrDir;
    logic              wrSet;
    logic              wrClr;
    logic              wrRise;
    logic              wrFall;
    logic              wrEdge;
    logic              wrAltLo;
    logic              wrAltHi;
    logic [BANK_W-1:0] bank;
  } strobeT;

  function automatic int bankOffset(int b);
    return (b < LOW_BANKS) ? b * 4 : HIGH_BASE + (b - LOW_BANKS) * 4;
  endfunction

  function automatic regKindE groupKind(int g);
    case (g)
      0:       return K_LEVEL;
      1:       return K_DIR;
      2:       return K_SET;
      3:       return K_CLR;
      4:       return K_RISE;
      5:       return K_FALL;
      default: return K_EDGE;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] wakeMask(int b);
    case (b)
      0:       return PIN_W'(32'h8003FE1B);
      1:       return PIN_W'(32'h002001FC);
      2:       return PIN_W'(32'hEC080000);
      3:       return PIN_W'(32'h0012007F);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobeT            strb,
  output regKindE           rdKind,
  output logic [BANK_W-1:0] rdBank
);
  regKindE           kind;
  logic [BANK_W-1:0] bank;

  always_comb begin
    kind = K_NONE;
    bank = '0;
    if (int'(addr) < SPACE_END) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int g = 0; g < GROUPS; g++) begin
          if (int'(addr) == g * GROUP_STRIDE + bankOffset(b)) begin
            kind = groupKind(g);
            bank = BANK_W'(b);
          end
        end
        if (int'(addr) == ALT_BASE + b * ALT_STRIDE) begin
          kind = K_ALTLO;
          bank = BANK_W'(b);
        end
        if (int'(addr) == ALT_BASE + 4 + b * ALT_STRIDE) begin
          kind = K_ALTHI;
          bank = BANK_W'(b);
        end
      end
    end
  end

  always_comb begin
    strb.wrDir   = wrEn && (kind == K_DIR);
    strb.wrSet   = wrEn && (kind == K_SET);
    strb.wrClr   = wrEn && (kind == K_CLR);
    strb.wrRise  = wrEn && (kind == K_RISE);
    strb.wrFall  = wrEn && (kind == K_FALL);
    strb.wrEdge  = wrEn && (kind == K_EDGE);
    strb.wrAltLo = wrEn && (kind == K_ALTLO);
    strb.wrAltHi = wrEn && (kind == K_ALTHI);
    strb.bank    = bank;
  end

  assign rdKind = kind;
  assign rdBank = bank;
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strb,
  input  regKindE               rdKind,
  input  logic [BANK_W-1:0]     rdBank,
  input  logic [PIN_W-1:0]      wrData,
  input  logic [TOTAL_PINS-1:0] pinIn,
  input  logic                  cpuHalted,
  output logic [PIN_W-1:0]      rdData,
  output logic [TOTAL_PINS-1:0] pinOut,
  output logic                  irqPin0,
  output logic                  irqPin1,
  output logic                  irqOther,
  output logic                  wakeReq
);
  logic [PIN_W-1:0]     levelV [NUM_BANKS];
  logic [PIN_W-1:0]     dirV   [NUM_BANKS];
  logic [PIN_W-1:0]     riseV  [NUM_BANKS];
  logic [PIN_W-1:0]     fallV  [NUM_BANKS];
  logic [PIN_W-1:0]     edgeV  [NUM_BANKS];
  logic [PIN_W-1:0]     altLoV [NUM_BANKS];
  logic [PIN_W-1:0]     altHiV [NUM_BANKS];
  logic [NUM_BANKS-1:0] wakeHit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    localparam logic [BANK_W-1:0] IDX = BANK_W'(b);
    logic             hit;
    logic [PIN_W-1:0] dirQ, outQ, riseQ, fallQ, edgeQ, altLoQ, altHiQ;
    logic [PIN_W-1:0] syncA, syncB, prevQ, padIn, newEdge, clrMask;

    assign hit     = (strb.bank == IDX);
    assign padIn   = pinIn[b*PIN_W +: PIN_W];
    assign newEdge = ~dirQ & ((riseQ & syncB & ~prevQ) | (fallQ & ~syncB & prevQ));
    assign clrMask = (strb.wrEdge && hit) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ   <= '0;
        outQ   <= '0;
        riseQ  <= '0;
        fallQ  <= '0;
        edgeQ  <= '0;
        altLoQ <= '0;
        altHiQ <= '0;
        syncA  <= '0;
        syncB  <= '0;
        prevQ  <= '0;
      end else begin
        syncA <= padIn;
        syncB <= syncA;
        prevQ <= syncB;
        edgeQ <= (edgeQ & ~clrMask) | newEdge;
        if (strb.wrDir && hit)   dirQ   <= wrData;
        if (strb.wrSet && hit)   outQ   <= outQ | wrData;
        else if (strb.wrClr && hit) outQ <= outQ & ~wrData;
        if (strb.wrRise && hit)  riseQ  <= wrData;
        if (strb.wrFall && hit)  fallQ  <= wrData;
        if (strb.wrAltLo && hit) altLoQ <= wrData;
        if (strb.wrAltHi && hit) altHiQ <= wrData;
      end
    end

    assign pinOut[b*PIN_W +: PIN_W] = outQ & dirQ;
    assign levelV[b] = (outQ & dirQ) | (syncB & ~dirQ);
    assign dirV[b]   = dirQ;
    assign riseV[b]  = riseQ;
    assign fallV[b]  = fallQ;
    assign edgeV[b]  = edgeQ;
    assign altLoV[b] = altLoQ;
    assign altHiV[b] = altHiQ;
    assign wakeHit[b] = |((syncB ^ prevQ) & ~dirQ & wakeMask(b));
  end

  always_comb begin
    case (rdKind)
      K_LEVEL: rdData = levelV[rdBank];
      K_DIR:   rdData = dirV[rdBank];
      K_RISE:  rdData = riseV[rdBank];
      K_FALL:  rdData = fallV[rdBank];
      K_EDGE:  rdData = edgeV[rdBank];
      K_ALTLO: rdData = altLoV[rdBank];
      K_ALTHI: rdData = altHiV[rdBank];
      default: rdData = '0;
    endcase
  end

  always_comb begin
    irqOther = |edgeV[0][PIN_W-1:2];
    for (int b = 1; b < NUM_BANKS; b++) irqOther = irqOther | (|edgeV[b]);
  end

  assign irqPin0 = edgeV[0][0];
  assign irqPin1 = edgeV[0][1];
  assign wakeReq = cpuHalted & (|wakeHit);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [PIN_W-1:0]      wrData,
  output logic [PIN_W-1:0]      rdData,
  input  logic [TOTAL_PINS-1:0] pinIn,
  output logic [TOTAL_PINS-1:0] pinOut,
  input  logic                  cpuHalted,
  output logic                  irqPin0,
  output logic                  irqPin1,
  output logic                  irqOther,
  output logic                  wakeReq
);
  strobeT            strb;
  regKindE           rdKind;
  logic [BANK_W-1:0] rdBank;

  gpio_ctrl uCtrl (
    .wrEn   (wrEn),
    .addr   (addr),
    .strb   (strb),
    .rdKind (rdKind),
    .rdBank (rdBank)
  );

  gpio_datapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdKind    (rdKind),
    .rdBank    (rdBank),
    .wrData    (wrData),
    .pinIn     (pinIn),
    .cpuHalted (cpuHalted),
    .rdData    (rdData),
    .pinOut    (pinOut),
    .irqPin0   (irqPin0),
    .irqPin1   (irqPin1),
    .irqOther  (irqOther),
    .wakeReq   (wakeReq)
  );
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [PIN_W-1:0]      rdData,
  input logic [TOTAL_PINS-1:0] pinOut,
  input logic                  irqPin0
);
  // R2: a set write never drops a driven bank 0 bit
  a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('h018)) |=>
      ((pinOut[PIN_W-1:0] & $past(pinOut[PIN_W-1:0])) == $past(pinOut[PIN_W-1:0])));

  // R2: a clear write never raises a driven bank 0 bit
  a_r2_clear_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'('h024)) |=>
      ((pinOut[PIN_W-1:0] & ~$past(pinOut[PIN_W-1:0])) == '0));

  // R2: set and clear registers read as zero
  a_r2_write_only_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'('h018) || addr == ADDR_W'('h024) || addr == ADDR_W'('h118)) |-> (rdData == '0));

  // R10: writes beyond the register space leave driven pins alone
  a_r10_high_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) >= SPACE_END) |=> $stable(pinOut));

  // R7: pin 0 status, hence its interrupt, stays set without a write
  a_r7_irq0_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqPin0 && !wrEn) |=> irqPin0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .addr    (addr),
  .rdData  (rdData),
  .pinOut  (pinOut),
  .irqPin0 (irqPin0)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  logic         clk = 0, rstN = 0, wrEn = 0, cpuHalted = 0;
  logic [11:0]  addr = '0;
  logic [31:0]  wrData = '0;
  logic [127:0] pinIn = '0;
  logic [31:0]  rdData;
  logic [127:0] pinOut;
  logic         irqPin0, irqPin1, irqOther, wakeReq;

  gpio_bank_ctrl dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .pinIn(pinIn), .pinOut(pinOut), .cpuHalted(cpuHalted),
    .irqPin0(irqPin0), .irqPin1(irqPin1), .irqOther(irqOther), .wakeReq(wakeReq)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit [31:0] mDir[4], mOut[4], mRise[4], mFall[4], mEdge[4], mAlt[8];
  bit [31:0] inHist[3][4];  // [0] newest sample, [1] synchronized, [2] previous
  bit [31:0] wakeMaskT[4] = '{32'h8003FE1B, 32'h002001FC, 32'hEC080000, 32'h0012007F};

  // kinds: 0 none, 1 level, 2 dir, 3 set, 4 clr, 5 rise, 6 fall, 7 status, 8 altlo, 9 althi
  function automatic void decode(input int a, output int kind, output int bank);
    int grpBase[7] = '{'h00, 'h0C, 'h18, 'h24, 'h30, 'h3C, 'h48};
    kind = 0; bank = 0;
    if (a >= 'h200) return;
    for (int bk = 0; bk < 4; bk++) begin
      int bo = (bk == 3) ? 'h100 : bk * 4;
      for (int g = 0; g < 7; g++)
        if (a == grpBase[g] + bo) begin kind = g + 1; bank = bk; end
      if (a == 'h54 + 8 * bk) begin kind = 8; bank = bk; end
      if (a == 'h58 + 8 * bk) begin kind = 9; bank = bk; end
    end
  endfunction

  function automatic bit [31:0] modelRead(input int a);
    int k, b;
    decode(a, k, b);
    case (k)
      1: return (mOut[b] & mDir[b]) | (inHist[1][b] & ~mDir[b]);
      2: return mDir[b];
      5: return mRise[b];
      6: return mFall[b];
      7: return mEdge[b];
      8: return mAlt[2*b];
      9: return mAlt[2*b+1];
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input int k);
    case (k)
      0: return "R10";
      1: return "R3";
      3, 4: return "R2";
      7: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic modelStep();
    bit [31:0] fresh[4];
    int k, b;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        mDir[i] = 0; mOut[i] = 0; mRise[i] = 0; mFall[i] = 0; mEdge[i] = 0;
        mAlt[2*i] = 0; mAlt[2*i+1] = 0;
        for (int h = 0; h < 3; h++) inHist[h][i] = 0;
      end
      return;
    end
    for (int i = 0; i < 4; i++)
      fresh[i] = ~mDir[i] & ((mRise[i] & inHist[1][i] & ~inHist[2][i]) |
                             (mFall[i] & ~inHist[1][i] & inHist[2][i]));
    k = 0; b = 0;
    if (wrEn) decode(int'(addr), k, b);
    for (int i = 0; i < 4; i++)
      mEdge[i] = (mEdge[i] & ~((k == 7 && b == i) ? wrData : 32'h0)) | fresh[i];
    case (k)
      2: mDir[b] = wrData;
      3: mOut[b] = mOut[b] | wrData;
      4: mOut[b] = mOut[b] & ~wrData;
      5: mRise[b] = wrData;
      6: mFall[b] = wrData;
      8: mAlt[2*b] = wrData;
      9: mAlt[2*b+1] = wrData;
      default: ;
    endcase
    for (int i = 0; i < 4; i++) begin
      inHist[2][i] = inHist[1][i];
      inHist[1][i] = inHist[0][i];
      inHist[0][i] = pinIn[i*32 +: 32];
    end
  endtask

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    int k, b;
    bit [127:0] po;
    bit other, wk;
    decode(int'(addr), k, b);
    chk(rdData, modelRead(int'(addr)), tagOf(k), "read data");
    for (int i = 0; i < 4; i++) po[i*32 +: 32] = mOut[i] & mDir[i];
    chk(pinOut, po, "R4", "pinOut");
    other = |mEdge[0][31:2] | |mEdge[1] | |mEdge[2] | |mEdge[3];
    chk({irqPin0, irqPin1, irqOther}, {mEdge[0][0], mEdge[0][1], other}, "R8", "irq lines");
    wk = 0;
    for (int i = 0; i < 4; i++) wk |= |((inHist[1][i] ^ inHist[2][i]) & ~mDir[i] & wakeMaskT[i]);
    chk(wakeReq, cpuHalted & wk, "R9", "wakeReq");
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    #1;
    compareAll();
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    addr = 12'(a); wrData = d; wrEn = 1;
    tick();
    wrEn = 0;
  endtask

  task automatic expectRd(input int a, input bit [31:0] exp, input string tag);
    addr = 12'(a);
    #1;
    chk(rdData, exp, tag, $sformatf("literal read at %h", a));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (2) tick();
    expectRd('h00C, 0, "R11");
    expectRd('h048, 0, "R11");
    chk({pinOut, irqPin0, irqPin1, irqOther, wakeReq}, '0, "R11", "outputs in reset");
    @(negedge clk); rstN = 1;
    tick();

    // R1: map including the fourth bank and alternate words
    wr('h10C, 32'hCAFE0000);
    wr('h130, 32'h00000F0F);
    wr('h06C, 32'h00001111);
    wr('h070, 32'h00002222);
    wr('h054, 32'hA5A5A5A5);
    wr('h040, 32'h000000F0);
    expectRd('h10C, 32'hCAFE0000, "R1");
    expectRd('h130, 32'h00000F0F, "R1");
    expectRd('h06C, 32'h00001111, "R1");
    expectRd('h070, 32'h00002222, "R1");
    expectRd('h054, 32'hA5A5A5A5, "R1");

    // R3 / R4 / R2: mixed directions on bank 2
    wr('h014, 32'h0000FFFF);
    wr('h020, 32'h12345678);
    pinIn[64 +: 32] = 32'hABCD0000;
    tick(); tick();
    expectRd('h008, 32'hABCD5678, "R3");
    chk(pinOut[64 +: 32], 32'h00005678, "R4", "bank2 pinOut");
    wr('h02C, 32'h0000FF00);
    chk(pinOut[64 +: 32], 32'h00000078, "R2", "after clear");
    expectRd('h020, 0, "R2");
    expectRd('h02C, 0, "R2");

    // R5: rising capture on bank 0 bits 0 and 2
    wr('h030, 32'h5);
    pinIn[2:0] = 3'b111;
    tick(); tick(); tick();
    expectRd('h048, 32'h5, "R5");
    chk({irqPin0, irqPin1, irqOther}, 3'b101, "R8", "irq after rise");
    wr('h048, 32'h5);
    expectRd('h048, 32'h0, "R7");

    // R6: falling capture on bank 1, bit 7 is an output
    wr('h010, 32'h80);
    pinIn[32 +: 32] = 32'hFF;
    repeat (3) tick();
    expectRd('h04C, 32'h0, "R6");
    pinIn[32 +: 32] = 32'h0;
    repeat (3) tick();
    expectRd('h04C, 32'h70, "R6");

    // R7: clear collides with a new falling edge on bit 4
    pinIn[36] = 1'b1;
    repeat (3) tick();
    pinIn[36] = 1'b0;
    tick(); tick();
    wr('h04C, 32'h70);
    expectRd('h04C, 32'h10, "R7");
    chk(irqOther, 1'b1, "R8", "irqOther from bank1");
    wr('h04C, 32'h0);
    expectRd('h04C, 32'h10, "R7");
    wr('h04C, 32'h10);
    chk(irqOther, 1'b0, "R8", "irqOther cleared");

    // R8: pin 1 falling
    wr('h03C, 32'h2);
    pinIn[1] = 1'b0;
    repeat (3) tick();
    chk({irqPin0, irqPin1, irqOther}, 3'b010, "R8", "irq pin1 only");

    // R9: wake from a masked pin only while halted
    cpuHalted = 1;
    pinIn[0] = 1'b0;
    tick(); tick();
    chk(wakeReq, 1'b1, "R9", "masked pin change");
    tick();
    chk(wakeReq, 1'b0, "R9", "after change settles");
    pinIn[2] = 1'b0;
    tick(); tick();
    chk(wakeReq, 1'b0, "R9", "unmasked pin change");
    cpuHalted = 0;
    pinIn[0] = 1'b1;
    tick(); tick();
    chk(wakeReq, 1'b0, "R9", "not halted");

    // R10: out-of-range and unmapped offsets
    wr('h118, 32'h0000FFFF);
    wr('h318, 32'hFFFF0000);
    chk(pinOut[96 +: 32], 32'h0, "R10", "bank3 pins (inputs)");
    wr('h10C, 32'hFFFFFFFF);
    chk(pinOut[96 +: 32], 32'h0000FFFF, "R10", "alias write ignored");
    wr('h324, 32'hFFFFFFFF);
    chk(pinOut[96 +: 32], 32'h0000FFFF, "R10", "alias clear ignored");
    wr('h104, 32'hFFFFFFFF);
    wr('h074, 32'hFFFFFFFF);
    expectRd('h104, 0, "R10");
    expectRd('h074, 0, "R10");
    expectRd('h218, 0, "R10");
    expectRd('h30C, 0, "R10");

    // mixed random traffic, compared every clock
    for (int n = 0; n < 600; n++) begin
      int sel = $urandom_range(0, 12);
      int bk = $urandom_range(0, 3);
      int off = (bk == 3) ? 'h100 : bk * 4;
      pinIn = {$urandom, $urandom, $urandom, $urandom};
      cpuHalted = $urandom_range(0, 1);
      if (sel < 7) begin
        addr = 12'(sel * 12 + off); wrData = $urandom; wrEn = $urandom_range(0, 1);
      end else if (sel < 9) begin
        addr = 12'('h54 + 8 * bk + 4 * (sel - 7)); wrData = $urandom; wrEn = 1;
      end else begin
        addr = 12'($urandom_range(0, 'hFFF)); wrData = $urandom; wrEn = $urandom_range(0, 1);
      end
      tick();
      wrEn = 0;
    end

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule